// File: doc/BRIEF.md
# Instruction Control Sequencer

This block is the control state machine of a small 16-bit load/store processor with eight general registers. R7 is the program counter, and a status word holds an interrupt-enable bit and NZVC flags. The sequencer does not store registers or compute results. It reads the instruction register, the branch-decision input, the interrupt request and the interrupt-enable bit. It then walks a fixed list of states for each instruction class. In each state it drives the register selects, a constant for the B bus, the ALU mode, the register, status and flag write strobes, and the memory read, write, size and data-phase strobes.

Interrupts use no stack. On entry the block stores the status word and then the PC at two fixed memory words, clears interrupt-enable, and loads a fixed vector into the PC. A return-from-interrupt instruction reads both words back. The PC is an ordinary register, so a branch is an ALU add whose write to R7 is enabled or not. Returns and table jumps need no dedicated states.

The instruction register is treated as transparent: during the second fetch state, `ir_i` must already carry the word being fetched, because the next state is chosen from it at the end of that cycle.

Top module: `instr_seq`

## Requirements
- R1: While `rst_i` is high the state is 0 and `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `ir_we_o`, `ps_we_o`, `flags_we_o` and `halt_o` are low. The first rising edge after release moves to state 1, which is equally quiet. The next edge goes to state 2 (fetch) or, when an interrupt is pending, to state 4.
- R2: Fetch takes two states. State 2 puts R7 on A with constant 0 on B, mode ADD (0), and raises a word read. State 3 raises `ir_we_o` and writes R7 + PC_STEP back to R7.
- R3: Instruction fields are major [15:13], A [12:10], D [9:7], B [6:4] and minor [3:0]. Major 000 is a branch when {[12:10],[0]} is nonzero; otherwise it is miscellaneous, with [2:1] selecting HALT 00, IRET 01, WRPS 10 and RDPS 11. Major 001 is arithmetic, 010 a byte store, 011 a word store, 100 address-add (LDA), 101 and 111 word loads, and 110 a byte load.
- R4: Arithmetic takes one state. It selects A and B from the fields, uses ALU mode MINOR (3), writes D and raises `flags_we_o`.
- R5: A branch takes one state. It puts R7 on A with constant sign-extend([9:1]) shifted left by one, uses mode ADD, and writes R7 only when `br_true_i` is high.
- R6: HALT, WRPS and RDPS each take one state. HALT drives the B field through PASS_B (2) with `halt_o`. WRPS does the same with `ps_we_o`. RDPS puts the status word on A (PASS_A, 1) and writes it to D.
- R7: LDA takes one state. It adds the sign-extended 7-bit offset [6:0] to A and writes D.
- R8: A load forms A + offset with a read, then writes the memory data to D. A third state, adding PC_STEP to R7, follows only when A is 7 and the offset is 0.
- R9: A store takes two states: A + offset with a write request, then D through PASS_B with `mem_data_o`.
- R10: IRET takes four states: a read of SAVE_PC_ADDR written into R7, then a read of SAVE_PS_ADDR written into the status word.
- R11: Interrupt entry uses states 4 to 8. It writes at SAVE_PS_ADDR with the status word as data, then at SAVE_PC_ADDR with R7 as data while raising `ie_clr_o`, then writes VEC_ADDR to R7 and goes straight to fetch.
- R12: At an instruction boundary, entry is taken only when `irq_i` and `ie_i` are both high in the last cycle of the instruction. Otherwise fetch follows.
- R13: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| ir_i | input | 16 | Instruction register (transparent during fetch state 3) |
| br_true_i | input | 1 | Branch condition satisfied |
| irq_i | input | 1 | Interrupt request |
| ie_i | input | 1 | Interrupt-enable bit of the status word |
| state_o | output | 5 | Current state code |
| a_sel_o | output | 3 | Register driven onto the A bus |
| b_sel_o | output | 3 | Register driven onto the B bus |
| d_sel_o | output | 3 | Destination register |
| b_const_o | output | 1 | B bus carries `const_o` instead of a register |
| const_o | output | 16 | Constant for the B bus |
| a_ps_o | output | 1 | A bus carries the status word |
| alu_mode_o | output | 2 | 0 ADD, 1 PASS_A, 2 PASS_B, 3 minor opcode |
| reg_we_o | output | 1 | Write destination register |
| d_from_mem_o | output | 1 | Result bus takes memory read data |
| flags_we_o | output | 1 | Update NZVC |
| ps_we_o | output | 1 | Write status word from result bus |
| ie_clr_o | output | 1 | Clear interrupt-enable |
| ir_we_o | output | 1 | Capture instruction |
| mem_rd_o | output | 1 | Memory read, address on result bus |
| mem_wr_o | output | 1 | Memory write, address on result bus |
| mem_word_o | output | 1 | Word access (low means byte) |
| mem_data_o | output | 1 | Result bus carries write data |
| halt_o | output | 1 | Halt indication |

## Verification
The bench builds the block with its default parameters: PC register 7, a PC step of 2, vector 0002, and save words FFFC and FFFE. With these values the expected constants and address sequences can be written out from the requirements alone. The immediate-word load path is reached through A = 7 with a zero offset. The vector and both save addresses are visible on `const_o` during interrupt entry and IRET. Every instruction class runs from one vector table, which counts execute states and PC writes. Directed runs cover the displacement and offset sign extension and the interrupt paths, both taken and masked.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  localparam int unsigned W     = 16;
  localparam int unsigned RW    = 3;
  localparam int unsigned OFFW  = 7;
  localparam int unsigned DISPW = 9;

  typedef logic [W-1:0]  word_t;
  typedef logic [RW-1:0] rsel_t;

  typedef enum logic [4:0] {
    ST_RST0   = 5'd0,
    ST_RST1   = 5'd1,
    ST_FETCH1 = 5'd2,
    ST_FETCH2 = 5'd3,
    ST_IREQ1  = 5'd4,
    ST_IREQ2  = 5'd5,
    ST_IREQ3  = 5'd6,
    ST_IREQ4  = 5'd7,
    ST_IREQ5  = 5'd8,
    ST_BCC1   = 5'd9,
    ST_ARITH1 = 5'd10,
    ST_LDA1   = 5'd11,
    ST_LOAD1  = 5'd12,
    ST_LOAD2  = 5'd13,
    ST_LOAD3  = 5'd14,
    ST_STORE1 = 5'd15,
    ST_STORE2 = 5'd16,
    ST_RDPS1  = 5'd17,
    ST_WRPS1  = 5'd18,
    ST_HALT1  = 5'd19,
    ST_IRET1  = 5'd20,
    ST_IRET2  = 5'd21,
    ST_IRET3  = 5'd22,
    ST_IRET4  = 5'd23
  } seq_state_t;

  typedef enum logic [1:0] {
    ALU_ADD    = 2'd0,
    ALU_PASS_A = 2'd1,
    ALU_PASS_B = 2'd2,
    ALU_MINOR  = 2'd3
  } alu_mode_t;

  typedef enum logic [3:0] {
    C_BRANCH, C_HALT, C_IRET, C_WRPS, C_RDPS,
    C_ARITH, C_LDA, C_LOAD, C_STORE
  } iclass_t;

  typedef struct packed {
    iclass_t cls;
    rsel_t   a;
    rsel_t   d;
    rsel_t   b;
    logic    byte_op;
    word_t   off;
    word_t   disp;
  } fields_t;

  typedef struct packed {
    rsel_t     a_sel;
    rsel_t     b_sel;
    rsel_t     d_sel;
    logic      b_const;
    word_t     konst;
    logic      a_ps;
    alu_mode_t alu;
    logic      reg_we;
    logic      d_from_mem;
    logic      flags_we;
    logic      ps_we;
    logic      ie_clr;
    logic      ir_we;
    logic      mem_rd;
    logic      mem_wr;
    logic      mem_word;
    logic      mem_data;
    logic      halt;
  } ctrl_t;

  // 7-bit signed byte offset, sign-extended to a full word
  function automatic word_t byte_offset(input word_t ir);
    return {{(W-OFFW){ir[OFFW-1]}}, ir[OFFW-1:0]};
  endfunction

  // 9-bit signed word displacement, sign-extended and scaled to bytes
  function automatic word_t branch_disp(input word_t ir);
    return {{(W-DISPW-1){ir[DISPW]}}, ir[DISPW:1], 1'b0};
  endfunction

  function automatic logic branch_cond_set(input word_t ir);
    return |{ir[12:10], ir[0]};
  endfunction

  function automatic iclass_t classify(input word_t ir);
    iclass_t c;
    unique case (ir[15:13])
      3'b000: begin
        if (branch_cond_set(ir)) c = C_BRANCH;
        else begin
          unique case (ir[2:1])
            2'b00:   c = C_HALT;
            2'b01:   c = C_IRET;
            2'b10:   c = C_WRPS;
            default: c = C_RDPS;
          endcase
        end
      end
      3'b001:         c = C_ARITH;
      3'b010, 3'b011: c = C_STORE;
      3'b100:         c = C_LDA;
      default:        c = C_LOAD;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import instr_seq_pkg::*;
#(
  parameter rsel_t PC_REG = 3'd7
) (
  input  word_t   ir_i,
  output fields_t f_o,
  output logic    imm_pc_o
);
  always_comb begin
    f_o.cls     = classify(ir_i);
    f_o.a       = ir_i[12:10];
    f_o.d       = ir_i[9:7];
    f_o.b       = ir_i[6:4];
    f_o.byte_op = ~ir_i[13];
    f_o.off     = byte_offset(ir_i);
    f_o.disp    = branch_disp(ir_i);
  end

  // load through the PC with zero offset fetches an inline word
  assign imm_pc_o = (f_o.cls == C_LOAD) && (f_o.a == PC_REG)
                    && (ir_i[OFFW-1:0] == '0);
endmodule

// File: rtl/seq_next.sv
module seq_next
  import instr_seq_pkg::*;
(
  input  seq_state_t state_i,
  input  iclass_t    cls_i,
  input  logic       imm_pc_i,
  input  logic       irq_i,
  input  logic       ie_i,
  output seq_state_t next_o
);
  seq_state_t boundary;
  assign boundary = (irq_i && ie_i) ? ST_IREQ1 : ST_FETCH1;

  always_comb begin
    next_o = boundary;
    unique case (state_i)
      ST_RST0:   next_o = ST_RST1;
      ST_FETCH1: next_o = ST_FETCH2;
      ST_FETCH2: begin
        unique case (cls_i)
          C_BRANCH: next_o = ST_BCC1;
          C_HALT:   next_o = ST_HALT1;
          C_IRET:   next_o = ST_IRET1;
          C_WRPS:   next_o = ST_WRPS1;
          C_RDPS:   next_o = ST_RDPS1;
          C_ARITH:  next_o = ST_ARITH1;
          C_LDA:    next_o = ST_LDA1;
          C_LOAD:   next_o = ST_LOAD1;
          default:  next_o = ST_STORE1;
        endcase
      end
      ST_IREQ1:  next_o = ST_IREQ2;
      ST_IREQ2:  next_o = ST_IREQ3;
      ST_IREQ3:  next_o = ST_IREQ4;
      ST_IREQ4:  next_o = ST_IREQ5;
      ST_IREQ5:  next_o = ST_FETCH1;
      ST_LOAD1:  next_o = ST_LOAD2;
      ST_LOAD2:  next_o = imm_pc_i ? ST_LOAD3 : boundary;
      ST_STORE1: next_o = ST_STORE2;
      ST_IRET1:  next_o = ST_IRET2;
      ST_IRET2:  next_o = ST_IRET3;
      ST_IRET3:  next_o = ST_IRET4;
      default:   next_o = boundary;
    endcase
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import instr_seq_pkg::*;
#(
  parameter rsel_t PC_REG       = 3'd7,
  parameter word_t PC_STEP      = 16'h0002,
  parameter word_t VEC_ADDR     = 16'h0002,
  parameter word_t SAVE_PC_ADDR = 16'hFFFC,
  parameter word_t SAVE_PS_ADDR = 16'hFFFE
) (
  input  seq_state_t state_i,
  input  fields_t    f_i,
  input  logic       br_true_i,
  output ctrl_t      c_o
);
  always_comb begin
    c_o     = '0;
    c_o.alu = ALU_ADD;
    unique case (state_i)
      ST_FETCH1: begin
        c_o.a_sel = PC_REG; c_o.b_const = 1'b1; c_o.konst = '0;
        c_o.mem_rd = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_FETCH2: begin
        c_o.a_sel = PC_REG; c_o.b_const = 1'b1; c_o.konst = PC_STEP;
        c_o.d_sel = PC_REG; c_o.reg_we = 1'b1; c_o.ir_we = 1'b1;
      end
      ST_IREQ1: begin
        c_o.b_const = 1'b1; c_o.konst = SAVE_PS_ADDR; c_o.alu = ALU_PASS_B;
        c_o.mem_wr = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_IREQ2: begin
        c_o.a_ps = 1'b1; c_o.alu = ALU_PASS_A;
        c_o.mem_data = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_IREQ3: begin
        c_o.b_const = 1'b1; c_o.konst = SAVE_PC_ADDR; c_o.alu = ALU_PASS_B;
        c_o.mem_wr = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_IREQ4: begin
        c_o.a_sel = PC_REG; c_o.alu = ALU_PASS_A;
        c_o.mem_data = 1'b1; c_o.mem_word = 1'b1; c_o.ie_clr = 1'b1;
      end
      ST_IREQ5: begin
        c_o.b_const = 1'b1; c_o.konst = VEC_ADDR; c_o.alu = ALU_PASS_B;
        c_o.d_sel = PC_REG; c_o.reg_we = 1'b1;
      end
      ST_BCC1: begin
        c_o.a_sel = PC_REG; c_o.b_const = 1'b1; c_o.konst = f_i.disp;
        c_o.d_sel = PC_REG; c_o.reg_we = br_true_i;
      end
      ST_ARITH1: begin
        c_o.a_sel = f_i.a; c_o.b_sel = f_i.b; c_o.d_sel = f_i.d;
        c_o.alu = ALU_MINOR; c_o.reg_we = 1'b1; c_o.flags_we = 1'b1;
      end
      ST_LDA1: begin
        c_o.a_sel = f_i.a; c_o.b_const = 1'b1; c_o.konst = f_i.off;
        c_o.d_sel = f_i.d; c_o.reg_we = 1'b1;
      end
      ST_LOAD1: begin
        c_o.a_sel = f_i.a; c_o.b_const = 1'b1; c_o.konst = f_i.off;
        c_o.mem_rd = 1'b1; c_o.mem_word = ~f_i.byte_op;
      end
      ST_LOAD2: begin
        c_o.d_sel = f_i.d; c_o.reg_we = 1'b1; c_o.d_from_mem = 1'b1;
        c_o.mem_word = ~f_i.byte_op;
      end
      ST_LOAD3: begin
        c_o.a_sel = PC_REG; c_o.b_const = 1'b1; c_o.konst = PC_STEP;
        c_o.d_sel = PC_REG; c_o.reg_we = 1'b1;
      end
      ST_STORE1: begin
        c_o.a_sel = f_i.a; c_o.b_const = 1'b1; c_o.konst = f_i.off;
        c_o.mem_wr = 1'b1; c_o.mem_word = ~f_i.byte_op;
      end
      ST_STORE2: begin
        c_o.b_sel = f_i.d; c_o.alu = ALU_PASS_B;
        c_o.mem_data = 1'b1; c_o.mem_word = ~f_i.byte_op;
      end
      ST_RDPS1: begin
        c_o.a_ps = 1'b1; c_o.alu = ALU_PASS_A;
        c_o.d_sel = f_i.d; c_o.reg_we = 1'b1;
      end
      ST_WRPS1: begin
        c_o.b_sel = f_i.b; c_o.alu = ALU_PASS_B; c_o.ps_we = 1'b1;
      end
      ST_HALT1: begin
        c_o.b_sel = f_i.b; c_o.alu = ALU_PASS_B; c_o.halt = 1'b1;
      end
      ST_IRET1: begin
        c_o.b_const = 1'b1; c_o.konst = SAVE_PC_ADDR; c_o.alu = ALU_PASS_B;
        c_o.mem_rd = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_IRET2: begin
        c_o.d_sel = PC_REG; c_o.reg_we = 1'b1; c_o.d_from_mem = 1'b1;
        c_o.mem_word = 1'b1;
      end
      ST_IRET3: begin
        c_o.b_const = 1'b1; c_o.konst = SAVE_PS_ADDR; c_o.alu = ALU_PASS_B;
        c_o.mem_rd = 1'b1; c_o.mem_word = 1'b1;
      end
      ST_IRET4: begin
        c_o.ps_we = 1'b1; c_o.d_from_mem = 1'b1; c_o.mem_word = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import instr_seq_pkg::*;
#(
  parameter rsel_t PC_REG       = 3'd7,
  parameter word_t PC_STEP      = 16'h0002,
  parameter word_t VEC_ADDR     = 16'h0002,
  parameter word_t SAVE_PC_ADDR = 16'hFFFC,
  parameter word_t SAVE_PS_ADDR = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [W-1:0]  ir_i,
  input  logic          br_true_i,
  input  logic          irq_i,
  input  logic          ie_i,
  output logic [4:0]    state_o,
  output logic [RW-1:0] a_sel_o,
  output logic [RW-1:0] b_sel_o,
  output logic [RW-1:0] d_sel_o,
  output logic          b_const_o,
  output logic [W-1:0]  const_o,
  output logic          a_ps_o,
  output logic [1:0]    alu_mode_o,
  output logic          reg_we_o,
  output logic          d_from_mem_o,
  output logic          flags_we_o,
  output logic          ps_we_o,
  output logic          ie_clr_o,
  output logic          ir_we_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mem_word_o,
  output logic          mem_data_o,
  output logic          halt_o
);
  seq_state_t state_q, state_d;
  fields_t    fields;
  logic       imm_pc;
  ctrl_t      ctl;

  seq_decode #(.PC_REG(PC_REG)) u_decode (
    .ir_i     (ir_i),
    .f_o      (fields),
    .imm_pc_o (imm_pc)
  );

  seq_next u_next (
    .state_i  (state_q),
    .cls_i    (fields.cls),
    .imm_pc_i (imm_pc),
    .irq_i    (irq_i),
    .ie_i     (ie_i),
    .next_o   (state_d)
  );

  seq_ctrl #(
    .PC_REG(PC_REG), .PC_STEP(PC_STEP), .VEC_ADDR(VEC_ADDR),
    .SAVE_PC_ADDR(SAVE_PC_ADDR), .SAVE_PS_ADDR(SAVE_PS_ADDR)
  ) u_ctrl (
    .state_i   (state_q),
    .f_i       (fields),
    .br_true_i (br_true_i),
    .c_o       (ctl)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) state_q <= ST_RST0;
    else       state_q <= state_d;
  end

  assign state_o      = state_q;
  assign a_sel_o      = ctl.a_sel;
  assign b_sel_o      = ctl.b_sel;
  assign d_sel_o      = ctl.d_sel;
  assign b_const_o    = ctl.b_const;
  assign const_o      = ctl.konst;
  assign a_ps_o       = ctl.a_ps;
  assign alu_mode_o   = ctl.alu;
  assign reg_we_o     = ctl.reg_we;
  assign d_from_mem_o = ctl.d_from_mem;
  assign flags_we_o   = ctl.flags_we;
  assign ps_we_o      = ctl.ps_we;
  assign ie_clr_o     = ctl.ie_clr;
  assign ir_we_o      = ctl.ir_we;
  assign mem_rd_o     = ctl.mem_rd;
  assign mem_wr_o     = ctl.mem_wr;
  assign mem_word_o   = ctl.mem_word;
  assign mem_data_o   = ctl.mem_data;
  assign halt_o       = ctl.halt;
endmodule

// File: rtl/instr_seq_checker.sv
module instr_seq_checker
  import instr_seq_pkg::*;
#(
  parameter word_t SAVE_PC_ADDR = 16'hFFFC
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       br_true_i,
  input logic       irq_i,
  input logic       ie_i,
  input logic [4:0] state_o,
  input logic [W-1:0] const_o,
  input logic       reg_we_o,
  input logic       ie_clr_o,
  input logic       ir_we_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o
);
  assert_rdwr_exclusive_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    !(mem_rd_o && mem_wr_o));

  assert_post_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_RST1) |-> !(reg_we_o || mem_rd_o || mem_wr_o || ir_we_o));

  assert_capture_after_read_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ir_we_o |-> $past(mem_rd_o));

  assert_untaken_branch_holds_pc_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_BCC1 && !br_true_i) |-> !reg_we_o);

  assert_ie_clear_after_pc_save_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    ie_clr_o |-> ($past(mem_wr_o) && $past(const_o) == SAVE_PC_ADDR));

  assert_entry_needs_request_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_IREQ1) |-> $past(irq_i && ie_i));
endmodule

bind instr_seq instr_seq_checker #(.SAVE_PC_ADDR(SAVE_PC_ADDR)) u_checker (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .br_true_i (br_true_i),
  .irq_i     (irq_i),
  .ie_i      (ie_i),
  .state_o   (state_o),
  .const_o   (const_o),
  .reg_we_o  (reg_we_o),
  .ie_clr_o  (ie_clr_o),
  .ir_we_o   (ir_we_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o)
);

// File: tb/test_instr_seq.sv
module test_instr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ir  = '0;
  logic        br = 1'b0, irq = 1'b0, ie = 1'b0;

  logic [4:0]  st;
  logic [2:0]  a_sel, b_sel, d_sel;
  logic        b_const, a_ps, reg_we, d_from_mem, flags_we, ps_we, ie_clr;
  logic        ir_we, mem_rd, mem_wr, mem_word, mem_data, halt;
  logic [15:0] konst;
  logic [1:0]  alu_mode;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  instr_seq i_instr_seq (
    .clk_i(clk), .rst_i(rst), .ir_i(ir), .br_true_i(br), .irq_i(irq), .ie_i(ie),
    .state_o(st), .a_sel_o(a_sel), .b_sel_o(b_sel), .d_sel_o(d_sel),
    .b_const_o(b_const), .const_o(konst), .a_ps_o(a_ps), .alu_mode_o(alu_mode),
    .reg_we_o(reg_we), .d_from_mem_o(d_from_mem), .flags_we_o(flags_we),
    .ps_we_o(ps_we), .ie_clr_o(ie_clr), .ir_we_o(ir_we), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_word_o(mem_word), .mem_data_o(mem_data), .halt_o(halt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // starts with state 2 sampled; runs to the next fetch or interrupt entry
  task automatic run(input logic [15:0] w, input logic b,
                     output int ex, output int pcw, output int rd, output int wr,
                     output int hl, output int both, output logic [15:0] k1);
    int n;
    n = 0; pcw = 0; rd = 0; wr = 0; hl = 0; both = 0; k1 = '0;
    ir = w; br = b;
    do begin
      if (reg_we && d_sel == 3'd7) pcw++;
      if (mem_rd) rd++;
      if (mem_wr) wr++;
      if (mem_rd && mem_wr) both++;
      if (halt) hl++;
      if (n == 2) k1 = konst;
      n++;
      step();
    end while (!(st == 5'd2 || st == 5'd4) && n < 40);
    ex = n - 2;
  endtask

  // {ir, br, exec states, pc writes, reads, writes}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    36'h2530_0_1110, 36'h2391_0_1210, 36'h0404_1_1210, 36'h0404_0_1110,
    36'h0001_1_1210, 36'h0000_0_1110, 36'h0002_0_4230, 36'h0004_0_1110,
    36'h0386_0_1210, 36'h8985_0_1110, 36'hACFF_0_2120, 36'hBD00_0_3220,
    36'hDD00_0_3220, 36'hBD01_0_2120, 36'hECFF_0_2120, 36'h6504_0_2111,
    36'h4504_0_2111
  };

  initial begin
    int ex, pcw, rd, wr, hl, both;
    logic [15:0] k1;

    // R1: reset state
    step(); step(); step();
    check("R1 state in reset", st, 0);
    check("R1 strobes in reset", {reg_we, mem_rd, mem_wr, ir_we, ps_we, flags_we, halt}, 0);
    @(negedge clk) rst = 1'b0;
    step();
    check("R1 first state after release", st, 1);
    check("R1 quiet after release", {reg_we, mem_rd, mem_wr, ir_we}, 0);
    step();
    // R2: fetch address phase
    check("R2 fetch state", st, 2);
    check("R2 fetch controls", {mem_rd, mem_word, b_const, a_sel}, {3'b111, 3'd7});
    check("R2 fetch address constant", konst, 16'h0000);
    ir = 16'h2530;
    step();
    check("R2 capture controls", {ir_we, reg_we, d_sel}, {2'b11, 3'd7});
    check("R2 pc step", konst, 16'h0002);
    step();
    // R4: arithmetic A=1 D=2 B=3
    check("R4 selects", {a_sel, b_sel, d_sel}, {3'd1, 3'd3, 3'd2});
    check("R4 mode and strobes", {alu_mode, reg_we, flags_we}, {2'd3, 2'b11});
    step();
    check("R4 back to fetch", st, 2);

    // R3: every class through the vector table
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][35:20], VEC[i][16], ex, pcw, rd, wr, hl, both, k1);
      check($sformatf("R3 vec %0d exec states", i), ex, int'(VEC[i][15:12]));
      check($sformatf("R3 vec %0d pc writes", i), pcw, int'(VEC[i][11:8]));
      check($sformatf("R3 vec %0d reads/writes", i), {rd[3:0], wr[3:0]}, int'(VEC[i][7:0]));
    end

    // R5: negative displacement, taken
    run(16'h03FF, 1'b1, ex, pcw, rd, wr, hl, both, k1);
    check("R5 displacement -1 word", k1, 16'hFFFE);
    check("R5 taken writes pc", pcw, 2);
    run(16'h0404, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R5 displacement +2 words", k1, 16'h0004);
    check("R5 untaken keeps pc", pcw, 1);

    // R6: halt and status read into R7
    run(16'h0070, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R6 halt raised once", hl, 1);
    run(16'h0386, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R6 rdps to R7", pcw, 2);

    // R7: offset sign extension
    run(16'h8940, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R7 offset -64", k1, 16'hFFC0);
    // R8: load offset -1 and immediate word path
    run(16'hACFF, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R8 load offset -1", k1, 16'hFFFF);
    run(16'hBD00, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R8 immediate load states", ex, 3);
    // R9 / R13: store
    run(16'h6504, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R9 store write once", wr, 1);
    check("R13 no read with write", both, 0);
    // R10: IRET
    run(16'h0002, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R10 iret first address", k1, 16'hFFFC);
    check("R10 iret pc reload", pcw, 2);

    // R12: request masked by ie low
    irq = 1'b1; ie = 1'b0;
    run(16'h2530, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R12 masked request ignored", st, 2);

    // R11/R12: taken entry
    ie = 1'b1;
    run(16'h2530, 1'b0, ex, pcw, rd, wr, hl, both, k1);
    check("R12 entry at boundary", st, 4);
    irq = 1'b0;
    begin
      int n, w, clr;
      logic [15:0] a1, a2, v;
      n = 0; w = 0; clr = 0; a1 = '0; a2 = '0; v = '0;
      while (st != 5'd2 && n < 20) begin
        if (mem_wr) begin
          if (w == 0) a1 = konst; else a2 = konst;
          w++;
        end
        if (ie_clr) begin clr++; ie = 1'b0; end
        if (reg_we && d_sel == 3'd7) v = konst;
        n++;
        step();
      end
      check("R11 entry states", n, 5);
      check("R11 status save address", a1, 16'hFFFE);
      check("R11 pc save address", a2, 16'hFFFC);
      check("R11 ie clear once", clr, 1);
      check("R11 vector to pc", v, 16'h0002);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule